// File: doc/BRIEF.md
# Six-Channel Converter Serial Data Port

This block is the digital serial port that sits behind a six-channel, 16-bit converter front end. The front end delivers one set of six conversion results, all taken at the same sampling instant, on a parallel bus with a one-cycle valid strobe. The port sends the set out as six 16-bit words, channel 0 first and MSB first. Each word is preceded by a one-period frame-sync pulse. The port also receives 16-bit control words, each marked by an input frame sync, and writes them into a small register file. The register file also drives the analog side.

The serial clock is made inside the block from the core clock. The core clock runs at twice the master-clock rate. The master-clock divider and the serial-clock divider are held in register 0, so one serial-clock period lasts M×S master-clock periods. Outgoing data moves on the serial clock's rising edge. Incoming data is taken on its falling edge. A port-enable input parks the whole port without losing register contents.

The transmitter walks through the states TX_IDLE, TX_SYNC and TX_SHIFT:
- TX_IDLE to TX_SYNC happens when a set is pending.
- TX_SYNC to TX_SHIFT always follows.
- TX_SHIFT to TX_SYNC happens after an LSB when another channel remains or a new set is pending.
- TX_SHIFT to TX_IDLE happens after the last LSB when nothing is pending.

The receiver has two states. RX_IDLE moves to RX_SHIFT on a sampled sync. RX_SHIFT returns to RX_IDLE after 16 bits.

Top module: `adc_serial_port`

## Requirements
- R1: After reset the register file is all zero, `ser_clk` is low, and with the port enabled `dout` and `dout_sync` drive 0.
- R2: With register 0 holding M in bits [2:0] and S in bits [5:3], a field value of 0 is taken as 1. One `ser_clk` period is 2×M×S core cycles: M×S cycles high, then M×S cycles low.
- R3: `dout` and `dout_sync` change only in the core cycle in which `ser_clk` rises.
- R4: `dout_sync` is high for exactly one `ser_clk` period, the period just before the MSB of each word, and is low during all 16 data bits.
- R5: A sample set is sent as six words in channel order 0..5. Channel c is `smp_data[16c+15:16c]`, sent MSB first. The sync periods of consecutive words in a set are 17 periods apart.
- R6: A set that arrives while a set is being sent waits until the last LSB of that set. A later arrival replaces an earlier waiting one. If a set is waiting at that LSB, its first sync follows in the very next period.
- R7: `din` and `din_sync` are sampled on falling edges of `ser_clk`. A sampled high sync makes the next 16 samples one control word, MSB first.
- R8: A control word writes register `word[9:8]` with `word[7:0]` only when bit 15 is 1 and bits [14:10] are 0. Any other word leaves all registers unchanged.
- R9: Register contents appear on `ctl_regs`, with register a at bits [8a+7:8a].
- R10: While `port_en` is low, `dout` and `dout_sync` are high-impedance, `ser_clk` stays low, and `din`/`din_sync` have no effect.
- R11: When `port_en` returns high, the registers and any waiting sample set are kept. The clock divider restarts, so the first `ser_clk` rise comes 2×M×S core cycles later, and transmission starts again from TX_IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, twice the master-clock rate |
| rst_n | input | 1 | Active-low reset |
| port_en | input | 1 | Port enable |
| smp_valid | input | 1 | One-cycle strobe: new sample set on smp_data |
| smp_data | input | 96 | Six 16-bit conversion words, channel 0 in the low bits |
| din | input | 1 | Serial control data in |
| din_sync | input | 1 | Input frame sync |
| ser_clk | output | 1 | Generated serial clock |
| dout | output | 1 | Serial conversion data out, tri-stated when disabled |
| dout_sync | output | 1 | Output frame sync, tri-stated when disabled |
| ctl_regs | output | 32 | Four 8-bit control registers |

## Verification
The assertions assume that `smp_valid` is a single-cycle pulse and that the host changes `din` and `din_sync` only just after a `ser_clk` rise, so the value is steady at the next fall. They also assume the host never starts a new control word inside the 16 data periods of another. The stimulus writes register 0 only while no sample set is in flight, so a period in progress is never cut short. Sample pushes and host writes are applied half a core cycle away from the active edge, and every host change is paced by observed `ser_clk` rises.

// File: rtl/adcsp_pkg.sv
package adcsp_pkg;
    typedef enum logic [1:0] {
        TX_IDLE,
        TX_SYNC,
        TX_SHIFT
    } tx_state_t;

    typedef enum logic {
        RX_IDLE,
        RX_SHIFT
    } rx_state_t;
endpackage

// File: rtl/sp_clkgen.sv
module sp_clkgen #(
    parameter int DIVW = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    input  logic [DIVW-1:0] mdiv,
    input  logic [DIVW-1:0] sdiv,
    output logic            sclk,
    output logic            rise_evt,
    output logic            fall_evt
);
    localparam int PW = 2 * DIVW;
    localparam int CW = PW + 1;

    logic [DIVW-1:0] mf, sf;
    logic [PW-1:0]   dprod;
    logic [CW-1:0]   cnt, full_m1, half_m1;

    always_comb begin
        mf      = (mdiv == '0) ? DIVW'(1) : mdiv;
        sf      = (sdiv == '0) ? DIVW'(1) : sdiv;
        dprod   = PW'(mf) * PW'(sf);
        full_m1 = {dprod, 1'b0} - CW'(1);
        half_m1 = {1'b0, dprod} - CW'(1);
    end

    assign rise_evt = en && (cnt >= full_m1);
    assign fall_evt = en && sclk && (cnt == half_m1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt  <= '0;
            sclk <= 1'b0;
        end else if (!en) begin
            cnt  <= '0;
            sclk <= 1'b0;
        end else if (rise_evt) begin
            cnt  <= '0;
            sclk <= 1'b1;
        end else begin
            cnt <= cnt + 1'b1;
            if (fall_evt) sclk <= 1'b0;
        end
    end
endmodule

// File: rtl/sp_tx.sv
module sp_tx
    import adcsp_pkg::*;
#(
    parameter int NCH   = 6,
    parameter int WBITS = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  en,
    input  logic                  rise_evt,
    input  logic                  smp_valid,
    input  logic [NCH*WBITS-1:0]  smp_data,
    output logic                  dout_q,
    output logic                  sync_q,
    output logic [$clog2(NCH)-1:0] ch_q
);
    localparam int CHW = $clog2(NCH);
    localparam int BW  = $clog2(WBITS);

    tx_state_t            state, nstate;
    logic [BW-1:0]        bit_q;
    logic [NCH*WBITS-1:0] pend, cur;
    logic                 pend_vld;
    logic [WBITS-1:0]     word;
    logic                 last_ch, load;

    assign word    = cur[ch_q*WBITS +: WBITS];
    assign last_ch = (ch_q == CHW'(NCH - 1));
    assign load    = rise_evt && pend_vld &&
                     ((state == TX_IDLE) ||
                      (state == TX_SHIFT && bit_q == '0 && last_ch));

    always_comb begin
        nstate = state;
        unique case (state)
            TX_IDLE:  if (pend_vld) nstate = TX_SYNC;
            TX_SYNC:  nstate = TX_SHIFT;
            TX_SHIFT: begin
                if (bit_q == '0) nstate = (!last_ch || pend_vld) ? TX_SYNC : TX_IDLE;
            end
            default:  nstate = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        state <= TX_IDLE;
        else if (!en)      state <= TX_IDLE;
        else if (rise_evt) state <= nstate;
    end

    // sample holding registers survive a disabled period
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend     <= '0;
            cur      <= '0;
            pend_vld <= 1'b0;
        end else begin
            if (load) cur <= pend;
            if (smp_valid) pend <= smp_data;
            pend_vld <= (pend_vld && !load) || smp_valid;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dout_q <= 1'b0;
            sync_q <= 1'b0;
            ch_q   <= '0;
            bit_q  <= '0;
        end else if (!en) begin
            dout_q <= 1'b0;
            sync_q <= 1'b0;
            ch_q   <= '0;
            bit_q  <= '0;
        end else if (rise_evt) begin
            unique case (state)
                TX_IDLE: begin
                    dout_q <= 1'b0;
                    sync_q <= pend_vld;
                    ch_q   <= '0;
                end
                TX_SYNC: begin
                    sync_q <= 1'b0;
                    dout_q <= word[WBITS-1];
                    bit_q  <= BW'(WBITS - 1);
                end
                TX_SHIFT: begin
                    if (bit_q != '0) begin
                        bit_q  <= bit_q - 1'b1;
                        dout_q <= word[bit_q - 1'b1];
                    end else if (!last_ch) begin
                        ch_q   <= ch_q + 1'b1;
                        sync_q <= 1'b1;
                        dout_q <= 1'b0;
                    end else begin
                        ch_q   <= '0;
                        sync_q <= pend_vld;
                        dout_q <= 1'b0;
                    end
                end
                default: begin
                    dout_q <= 1'b0;
                    sync_q <= 1'b0;
                end
            endcase
        end
    end
endmodule

// File: rtl/sp_rx.sv
module sp_rx
    import adcsp_pkg::*;
#(
    parameter int WBITS = 16,
    parameter int NREG  = 4,
    parameter int REGW  = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en,
    input  logic                 fall_evt,
    input  logic                 din,
    input  logic                 din_sync,
    output logic [NREG*REGW-1:0] regs_flat
);
    localparam int AW       = $clog2(NREG);
    localparam int CNTW     = $clog2(WBITS);
    localparam int ADDR_LSB = REGW;
    localparam int RSV_LSB  = REGW + AW;

    rx_state_t        state, nstate;
    logic [CNTW-1:0]  cnt;
    logic [WBITS-2:0] shreg;
    logic [WBITS-1:0] wr_word;
    logic             done, wr_ok;
    logic [REGW-1:0]  regs [NREG];

    assign wr_word = {shreg, din};
    assign done    = fall_evt && (state == RX_SHIFT) && (cnt == CNTW'(WBITS - 1));
    assign wr_ok   = wr_word[WBITS-1] && (wr_word[WBITS-2:RSV_LSB] == '0);

    always_comb begin
        nstate = state;
        unique case (state)
            RX_IDLE:  if (din_sync) nstate = RX_SHIFT;
            RX_SHIFT: if (cnt == CNTW'(WBITS - 1)) nstate = RX_IDLE;
            default:  nstate = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        state <= RX_IDLE;
        else if (!en)      state <= RX_IDLE;
        else if (fall_evt) state <= nstate;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt   <= '0;
            shreg <= '0;
        end else if (!en) begin
            cnt   <= '0;
            shreg <= '0;
        end else if (fall_evt) begin
            if (state == RX_SHIFT) begin
                shreg <= wr_word[WBITS-2:0];
                cnt   <= done ? '0 : cnt + 1'b1;
            end else begin
                cnt <= '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) regs[i] <= '0;
        end else if (done && wr_ok) begin
            regs[wr_word[ADDR_LSB +: AW]] <= wr_word[REGW-1:0];
        end
    end

    for (genvar g = 0; g < NREG; g++) begin : g_flat
        assign regs_flat[g*REGW +: REGW] = regs[g];
    end
endmodule

// File: rtl/adc_serial_port.sv
module adc_serial_port #(
    parameter int NCH   = 6,
    parameter int WBITS = 16,
    parameter int DIVW  = 3,
    parameter int NREG  = 4,
    parameter int REGW  = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 port_en,
    input  logic                 smp_valid,
    input  logic [NCH*WBITS-1:0] smp_data,
    input  logic                 din,
    input  logic                 din_sync,
    output logic                 ser_clk,
    output logic                 dout,
    output logic                 dout_sync,
    output logic [NREG*REGW-1:0] ctl_regs
);
    localparam int MDIV_LSB = 0;
    localparam int SDIV_LSB = DIVW;
    localparam int CHW      = $clog2(NCH);

    logic           rise_evt, fall_evt;
    logic           dout_q, sync_q;
    logic [CHW-1:0] tx_ch;

    sp_clkgen #(.DIVW(DIVW)) u_clkgen (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (port_en),
        .mdiv     (ctl_regs[MDIV_LSB +: DIVW]),
        .sdiv     (ctl_regs[SDIV_LSB +: DIVW]),
        .sclk     (ser_clk),
        .rise_evt (rise_evt),
        .fall_evt (fall_evt)
    );

    sp_tx #(.NCH(NCH), .WBITS(WBITS)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (port_en),
        .rise_evt  (rise_evt),
        .smp_valid (smp_valid),
        .smp_data  (smp_data),
        .dout_q    (dout_q),
        .sync_q    (sync_q),
        .ch_q      (tx_ch)
    );

    sp_rx #(.WBITS(WBITS), .NREG(NREG), .REGW(REGW)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (port_en),
        .fall_evt  (fall_evt),
        .din       (din),
        .din_sync  (din_sync),
        .regs_flat (ctl_regs)
    );

    assign dout      = port_en ? dout_q : 1'bz;
    assign dout_sync = port_en ? sync_q : 1'bz;
endmodule

// File: rtl/sp_checker.sv
module sp_checker #(
    parameter int NCH  = 6,
    parameter int NREG = 4,
    parameter int REGW = 8
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   port_en,
    input logic                   ser_clk,
    input logic                   dout_q,
    input logic                   sync_q,
    input logic                   fall_evt,
    input logic [NREG*REGW-1:0]   ctl_regs,
    input logic [$clog2(NCH)-1:0] tx_ch
);
    a_r10_clk_parked: assert property (@(posedge clk) disable iff (!rst_n)
        !port_en |=> !ser_clk);

    a_r3_moves_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (port_en && $past(port_en) && (!$stable(dout_q) || !$stable(sync_q)))
        |-> $rose(ser_clk));

    a_r4_sync_one_period: assert property (@(posedge clk) disable iff (!rst_n)
        (port_en && $past(port_en) && $rose(ser_clk) && $past(sync_q))
        |-> !sync_q);

    a_r7_write_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ctl_regs) |-> $past(fall_evt));

    a_r5_channel_range: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ch < NCH);
endmodule

bind adc_serial_port sp_checker #(.NCH(NCH), .NREG(NREG), .REGW(REGW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .port_en  (port_en),
    .ser_clk  (ser_clk),
    .dout_q   (dout_q),
    .sync_q   (sync_q),
    .fall_evt (fall_evt),
    .ctl_regs (ctl_regs),
    .tx_ch    (tx_ch)
);

// File: tb/adc_serial_port_test.sv
module adc_serial_port_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n, port_en, smp_valid, din, din_sync;
    logic [95:0] smp_data;
    logic [31:0] ctl_regs;
    logic        ser_clk;
    wire         dout_w, dsync_w;
    pullup (dout_w);
    pullup (dsync_w);

    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    adc_serial_port uut (
        .clk(clk), .rst_n(rst_n), .port_en(port_en), .smp_valid(smp_valid),
        .smp_data(smp_data), .din(din), .din_sync(din_sync), .ser_clk(ser_clk),
        .dout(dout_w), .dout_sync(dsync_w), .ctl_regs(ctl_regs)
    );

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // ---------------- output monitor (host receive side) ----------------
    logic        p_sc = 0, p_do = 0, p_sy = 0, p_en = 0;
    int          cyc = 0, rise_n = 0, last_rise = 0, gap = 0, hi_len = 0;
    bit          coll = 0;
    int          bcnt = 0, sync_rise = 0;
    logic [15:0] sh;
    logic [15:0] got [0:255];
    int          sync_at [0:255];
    int          lsb_at [0:255];
    int          got_n = 0;

    always @(negedge clk) begin
        cyc++;
        if (rst_n && port_en && p_en) begin
            if (!(ser_clk && !p_sc) && (dout_w !== p_do || dsync_w !== p_sy))
                check(0, "R3 output changed without ser_clk rise", {dout_w, dsync_w}, {p_do, p_sy});
            if (!ser_clk && p_sc) hi_len = cyc - last_rise;
            if (ser_clk && !p_sc) begin
                rise_n++;
                gap = cyc - last_rise;
                last_rise = cyc;
                if (coll) begin
                    if (dsync_w !== 1'b0) check(0, "R4 sync high during data bits", 1, 0);
                    sh = {sh[14:0], dout_w};
                    bcnt++;
                    if (bcnt == 16) begin
                        got[got_n & 255] = sh;
                        sync_at[got_n & 255] = sync_rise;
                        lsb_at[got_n & 255] = rise_n;
                        got_n++;
                        coll = 0;
                    end
                end else if (dsync_w === 1'b1) begin
                    coll = 1;
                    bcnt = 0;
                    sync_rise = rise_n;
                end
            end
        end else begin
            coll = 0;
        end
        p_sc = ser_clk; p_do = dout_w; p_sy = dsync_w; p_en = port_en;
    end

    // ---------------- helpers ----------------
    function automatic int dval(input logic [7:0] r0);
        int m = (r0[2:0] == 0) ? 1 : r0[2:0];
        int s = (r0[5:3] == 0) ? 1 : r0[5:3];
        return m * s;
    endfunction

    function automatic logic [15:0] mk_wr(input logic [1:0] a, input logic [7:0] d);
        return {1'b1, 5'b0, a, d};
    endfunction

    function automatic logic [95:0] rnd_set();
        return {$urandom, $urandom, $urandom};
    endfunction

    task automatic push(input logic [95:0] s);
        @(negedge clk);
        smp_data = s; smp_valid = 1'b1;
        @(negedge clk);
        smp_valid = 1'b0;
    endtask

    task automatic wait_rises(input int n);
        repeat (n) @(posedge ser_clk);
        @(negedge clk);
    endtask

    task automatic wait_words(input int n);
        int t = 0;
        while (got_n < n && t < 20000) begin
            @(negedge clk);
            t++;
        end
    endtask

    task automatic host_write(input logic [15:0] w);
        @(posedge ser_clk); @(negedge clk);
        din_sync = 1'b1; din = 1'b0;
        for (int i = 15; i >= 0; i--) begin
            @(posedge ser_clk); @(negedge clk);
            din_sync = 1'b0; din = w[i];
        end
        @(posedge ser_clk); @(negedge clk);
        din = 1'b0;
    endtask

    task automatic cmp_set(input int base, input logic [95:0] s, input string tag);
        for (int c = 0; c < 6; c++)
            check(got[(base + c) & 255] == s[c*16 +: 16], tag,
                  got[(base + c) & 255], s[c*16 +: 16]);
        for (int c = 0; c < 5; c++)
            check(sync_at[(base + c + 1) & 255] - sync_at[(base + c) & 255] == 17,
                  "R5 word spacing", sync_at[(base + c + 1) & 255] - sync_at[(base + c) & 255], 17);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog expired: actual running expected finished");
        summary();
    end

    // ---------------- main sequence ----------------
    logic [7:0]  mreg [0:3];
    logic [95:0] s_a, s_b, s_c;
    int          base, d, n;

    initial begin
        void'($urandom(32'd4242));
        rst_n = 0; port_en = 1; smp_valid = 0; smp_data = '0; din = 0; din_sync = 0;
        for (int i = 0; i < 4; i++) mreg[i] = 8'h00;
        repeat (5) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1 reset state
        check(ctl_regs == 32'h0, "R1 registers after reset", ctl_regs, 0);
        check(ser_clk == 1'b0, "R1 ser_clk after reset", ser_clk, 0);
        check(dout_w == 1'b0 && dsync_w == 1'b0, "R1 outputs driven low", {dout_w, dsync_w}, 0);

        // R2 default divide-by-one
        wait_rises(3);
        check(gap == 2, "R2 default period", gap, 2);
        check(hi_len == 1, "R2 default high time", hi_len, 1);

        // R5 directed channel order and bit order
        s_a = {16'h1234, 16'hFFFF, 16'h0001, 16'hA5C3, 16'h7FFE, 16'h8001};
        base = got_n;
        push(s_a);
        wait_words(base + 6);
        cmp_set(base, s_a, "R5 directed word");

        // R6 waiting set, replacement by newer set, seamless start
        s_a = rnd_set(); s_b = rnd_set(); s_c = rnd_set();
        base = got_n;
        push(s_a);
        wait_words(base + 2);
        push(s_b);
        push(s_c);
        wait_words(base + 12);
        cmp_set(base, s_a, "R6 first set");
        cmp_set(base + 6, s_c, "R6 newest waiting set");
        check(sync_at[(base + 6) & 255] == lsb_at[(base + 5) & 255] + 1, "R6 back-to-back sync",
              sync_at[(base + 6) & 255], lsb_at[(base + 5) & 255] + 1);

        // R8/R9/R2 write divider register: M=3, S=2
        host_write(mk_wr(2'd0, 8'h13));
        mreg[0] = 8'h13;
        check(ctl_regs[7:0] == 8'h13, "R9 register 0 field", ctl_regs[7:0], 8'h13);
        d = dval(mreg[0]);
        wait_rises(3);
        check(gap == 2 * d, "R2 divided period", gap, 2 * d);
        check(hi_len == d, "R2 divided high time", hi_len, d);

        // R7 random control writes
        for (int k = 0; k < 4; k++) begin
            logic [1:0] a;
            logic [7:0] v;
            a = 2'(1 + ($urandom % 3));
            v = 8'($urandom);
            host_write(mk_wr(a, v));
            mreg[a] = v;
            check(ctl_regs[a*8 +: 8] == v, "R7 control word written", ctl_regs[a*8 +: 8], v);
        end

        // R8 non-write and reserved-bit words ignored
        host_write({1'b0, 5'b0, 2'd1, ~mreg[1]});
        host_write({1'b1, 5'b00100, 2'd2, ~mreg[2]});
        check(ctl_regs == {mreg[3], mreg[2], mreg[1], mreg[0]}, "R8 ignored words",
              ctl_regs, {mreg[3], mreg[2], mreg[1], mreg[0]});

        // R5 random sets at the slower clock
        for (int k = 0; k < 2; k++) begin
            s_a = rnd_set();
            base = got_n;
            push(s_a);
            wait_words(base + 6);
            cmp_set(base, s_a, "R5 random word");
        end

        // R10 disabled port
        @(negedge clk);
        port_en = 1'b0;
        @(negedge clk);
        check(dout_w === 1'b1 && dsync_w === 1'b1, "R10 outputs released", {dout_w, dsync_w}, 2'b11);
        s_b = rnd_set();
        push(s_b);
        n = 0;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            din_sync = (i % 20 == 0);
            din = 1'b1;
            if (ser_clk !== 1'b0) n++;
        end
        din = 0; din_sync = 0;
        check(n == 0, "R10 ser_clk parked", n, 0);
        check(ctl_regs == {mreg[3], mreg[2], mreg[1], mreg[0]}, "R10 input ignored",
              ctl_regs, {mreg[3], mreg[2], mreg[1], mreg[0]});

        // R11 re-enable: registers kept, counters restarted, waiting set sent
        base = got_n;
        port_en = 1'b1;
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (ser_clk !== 1'b1 && n < 200);
        check(n == 2 * d, "R11 first rise after enable", n, 2 * d);
        check(ctl_regs == {mreg[3], mreg[2], mreg[1], mreg[0]}, "R11 registers retained",
              ctl_regs, {mreg[3], mreg[2], mreg[1], mreg[0]});
        wait_words(base + 6);
        cmp_set(base, s_b, "R11 waiting set kept");

        summary();
    end
endmodule